// File: doc/BRIEF.md
# MII Transmit Frame Capture with Carrier-Sense Flow Control

This block is the receiving end of a nibble-wide transmit path. A local host, clocked by the block's continuous transmit clock, presents four data bits per cycle together with an enable qualifier and an error flag. The block pairs nibbles into bytes and stores each frame in one of a small ring of frame buffers. A frame flagged as bad is dropped and never reaches the downstream side. Frames that are odd in nibble count or too long for a buffer are dropped in the same way.

Carrier sense acts as frame-level backpressure toward the host. It rises on the clock after the enable is first seen. It stays high until the frame has been committed and the next buffer in the ring is empty. The host waits for carrier sense to fall before it starts another frame.

The downstream consumer sees a ready flag and the byte length of the oldest stored frame. It reads bytes through an address port with one cycle of latency. A release pulse hands that buffer back to the ring. Frames come out in the order they were committed.

Top module: `mtc_tx_capture`

## Requirements
- R1: While reset is held, and after it is released with no traffic, `crs` and `frm_rdy` are low.
- R2: Nibbles are packed low first. The nibble sampled first in a pair becomes byte bits [3:0] and the second becomes bits [7:4].
- R3: `crs` is high on the first clock after `tx_en` is sampled high, and stays high for as long as `tx_en` stays high.
- R4: A frame ends on the first clock that samples `tx_en` low. If the next ring buffer is empty, `crs` falls on that same edge.
- R5: If `tx_er` is sampled high in any cycle where `tx_en` is high, the frame is discarded and `frm_rdy` does not rise for it.
- R6: A frame with an odd number of nibbles is discarded.
- R7: A frame longer than `BUF_BYTES` bytes (1536 by default) is discarded. A frame of exactly `BUF_BYTES` bytes is delivered. A delivered length is never zero and never exceeds `BUF_BYTES`.
- R8: When every buffer holds a committed frame, `crs` stays high. It falls on the edge that samples `frm_release` and frees the next buffer in the ring.
- R9: `frm_len` gives the byte count of the oldest committed frame. `rd_data` returns the byte at `rd_addr` one clock after that address is sampled. Frames are delivered in commit order, and `frm_rdy` stays high until the release.
- R10: A frame started while no buffer is free is discarded. Frames already stored are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous transmit clock shared with the host |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_en | input | 1 | Host marks `txd` as valid frame data |
| tx_er | input | 1 | Host flags the current frame as bad |
| txd | input | NIB_W | Transmit nibble |
| crs | output | 1 | Carrier sense; the host must not start a frame while high |
| frm_rdy | output | 1 | A committed frame is waiting downstream |
| frm_len | output | LEN_W | Byte length of the waiting frame |
| rd_addr | input | LEN_W | Byte offset within the waiting frame |
| rd_data | output | 2*NIB_W | Byte at the offset sampled on the previous clock |
| frm_release | input | 1 | Frees the waiting frame's buffer |

## Verification
The properties assume that `tx_en`, `tx_er` and `frm_release` are synchronous to `clk`. They also assume that a release arriving while `frm_rdy` is low has no meaning. They do not assume that the host honours carrier sense, so they still hold when a frame is forced in while the ring is full. The bench changes every input on the falling edge. It pulses the release only while a frame is waiting. It breaks the carrier-sense rule exactly once, on purpose, to exercise R10.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_RECV = 1'b1
  } cap_state_e;
endpackage

// File: rtl/mtc_nibble_pack.sv
module mtc_nibble_pack #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nib_vld,
  input  logic [NIB_W-1:0]   nib,
  output logic               half,
  output logic               byte_vld,
  output logic [2*NIB_W-1:0] byte_data
);
  logic             half_q, half_d;
  logic [NIB_W-1:0] lo_q, lo_d;

  always_comb begin
    half_d    = nib_vld ? ~half_q : 1'b0;
    lo_d      = (nib_vld && !half_q) ? nib : lo_q;
    byte_vld  = nib_vld & half_q;
    byte_data = {nib, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      half_q <= half_d;
      lo_q   <= lo_d;
    end
  end

  assign half = half_q;
endmodule

// File: rtl/mtc_buf_ring.sv
module mtc_buf_ring #(
  parameter int NUM_BUF = 2,
  parameter int LEN_W   = 11,
  parameter int IDX_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [LEN_W-1:0]   commit_len,
  input  logic               release_req,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [IDX_W-1:0]   rd_idx,
  output logic [NUM_BUF-1:0] full_vec,
  output logic               wr_full,
  output logic               rd_full,
  output logic [LEN_W-1:0]   rd_len
);
  logic [NUM_BUF-1:0] full_q, full_d;
  logic [LEN_W-1:0]   len_q [NUM_BUF];
  logic [LEN_W-1:0]   len_d [NUM_BUF];
  logic [IDX_W-1:0]   wr_idx_q, wr_idx_d, rd_idx_q, rd_idx_d;
  logic               release_ok;

  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(NUM_BUF - 1)) ? '0 : idx + 1'b1;
  endfunction

  always_comb begin
    release_ok = release_req & full_q[rd_idx_q];
    wr_idx_d   = commit     ? ring_next(wr_idx_q) : wr_idx_q;
    rd_idx_d   = release_ok ? ring_next(rd_idx_q) : rd_idx_q;
    for (int i = 0; i < NUM_BUF; i++) begin
      full_d[i] = full_q[i];
      len_d[i]  = len_q[i];
      if (release_ok && rd_idx_q == IDX_W'(i)) full_d[i] = 1'b0;
      if (commit && wr_idx_q == IDX_W'(i)) begin
        full_d[i] = 1'b1;
        len_d[i]  = commit_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= '0;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      for (int i = 0; i < NUM_BUF; i++) len_q[i] <= '0;
    end else begin
      full_q   <= full_d;
      wr_idx_q <= wr_idx_d;
      rd_idx_q <= rd_idx_d;
      for (int i = 0; i < NUM_BUF; i++) len_q[i] <= len_d[i];
    end
  end

  assign wr_idx   = wr_idx_q;
  assign rd_idx   = rd_idx_q;
  assign full_vec = full_q;
  assign wr_full  = full_q[wr_idx_q];
  assign rd_full  = full_q[rd_idx_q];
  assign rd_len   = len_q[rd_idx_q];
endmodule

// File: rtl/mtc_frame_mem.sv
module mtc_frame_mem #(
  parameter int NUM_BUF   = 2,
  parameter int BUF_BYTES = 1536,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 1,
  parameter int PTR_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_buf,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_buf,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH  = NUM_BUF * BUF_BYTES;
  localparam int MEM_AW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [MEM_AW-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] rd_data_q;

  always_comb begin
    wr_addr = MEM_AW'(wr_buf) * MEM_AW'(BUF_BYTES) + MEM_AW'(wr_ptr);
    rd_addr = MEM_AW'(rd_buf) * MEM_AW'(BUF_BYTES) + MEM_AW'(rd_ptr);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_q <= '0;
    else        rd_data_q <= (rd_addr < MEM_AW'(DEPTH)) ? mem_q[rd_addr] : '0;
  end

  assign rd_data = rd_data_q;
endmodule

// File: rtl/mtc_tx_capture.sv
module mtc_tx_capture #(
  parameter int NIB_W     = 4,
  parameter int NUM_BUF   = 2,
  parameter int BUF_BYTES = 1536,
  localparam int BYTE_W   = 2 * NIB_W,
  localparam int LEN_W    = $clog2(BUF_BYTES + 1),
  localparam int IDX_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [NIB_W-1:0]  txd,
  output logic              crs,
  output logic              frm_rdy,
  output logic [LEN_W-1:0]  frm_len,
  input  logic [LEN_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              frm_release
);
  import mtc_pkg::*;

  cap_state_e         state_q, state_d;
  logic [LEN_W-1:0]   ptr_q, ptr_d;
  logic               err_q, err_d;
  logic               commit, wr_en;
  logic               half, byte_vld;
  logic [BYTE_W-1:0]  byte_data;
  logic [IDX_W-1:0]   wr_idx, rd_idx;
  logic [NUM_BUF-1:0] full_vec;
  logic               wr_full, rd_full;
  logic [LEN_W-1:0]   rd_len;

  mtc_nibble_pack #(.NIB_W(NIB_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .nib_vld(tx_en), .nib(txd),
    .half(half), .byte_vld(byte_vld), .byte_data(byte_data)
  );

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    err_d   = err_q;
    commit  = 1'b0;
    wr_en   = 1'b0;
    unique case (state_q)
      CAP_IDLE: begin
        if (tx_en) begin
          state_d = CAP_RECV;
          ptr_d   = '0;
          err_d   = tx_er | wr_full;
        end
      end
      CAP_RECV: begin
        if (tx_en) begin
          if (tx_er) err_d = 1'b1;
          if (byte_vld) begin
            if (ptr_q == LEN_W'(BUF_BYTES)) err_d = 1'b1;
            else if (!err_q && !tx_er) begin
              wr_en = 1'b1;
              ptr_d = ptr_q + 1'b1;
            end
          end
        end else begin
          state_d = CAP_IDLE;
          commit  = !err_q && !half && (ptr_q != '0);
        end
      end
      default: state_d = CAP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      ptr_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      err_q   <= err_d;
    end
  end

  mtc_buf_ring #(.NUM_BUF(NUM_BUF), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_len(ptr_q),
    .release_req(frm_release), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .full_vec(full_vec), .wr_full(wr_full), .rd_full(rd_full), .rd_len(rd_len)
  );

  mtc_frame_mem #(
    .NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES), .DATA_W(BYTE_W),
    .IDX_W(IDX_W), .PTR_W(LEN_W)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_buf(wr_idx), .wr_ptr(ptr_q),
    .wr_data(byte_data), .rd_buf(rd_idx), .rd_ptr(rd_addr), .rd_data(rd_data)
  );

  assign crs     = (state_q == CAP_RECV) | wr_full;
  assign frm_rdy = rd_full;
  assign frm_len = rd_len;
endmodule

// File: rtl/mtc_tx_capture_chk.sv
module mtc_tx_capture_chk #(
  parameter int NUM_BUF   = 2,
  parameter int BUF_BYTES = 1536,
  parameter int LEN_W     = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_en,
  input logic               tx_er,
  input logic               crs,
  input logic               frm_rdy,
  input logic [LEN_W-1:0]   frm_len,
  input logic               frm_release,
  input logic [NUM_BUF-1:0] full_vec,
  input logic               err_q
);
  AST_CRS_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> crs); // R3

  AST_ERR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_er) |=> err_q); // R5

  AST_LEN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    frm_rdy |-> (frm_len != '0 && frm_len <= LEN_W'(BUF_BYTES))); // R7

  AST_RING_FULL_CRS: assert property (@(posedge clk) disable iff (!rst_n)
    (&full_vec) |-> crs); // R8

  AST_RDY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_rdy && !frm_release) |=> frm_rdy); // R9
endmodule

bind mtc_tx_capture mtc_tx_capture_chk #(
  .NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .crs(crs),
  .frm_rdy(frm_rdy), .frm_len(frm_len), .frm_release(frm_release),
  .full_vec(full_vec), .err_q(err_q)
);

// File: tb/sim_mtc_tx_capture.sv
module sim_mtc_tx_capture;
  localparam int BUF_BYTES = 1536;
  localparam int LEN_W     = $clog2(BUF_BYTES + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tx_en, tx_er, frm_release;
  logic [3:0]       txd;
  logic             crs, frm_rdy;
  logic [LEN_W-1:0] frm_len, rd_addr;
  logic [7:0]       rd_data;
  int               checks = 0;
  int               errors = 0;
  bit               done = 1'b0;

  always #5 clk = ~clk;

  mtc_tx_capture #(.NIB_W(4), .NUM_BUF(2), .BUF_BYTES(BUF_BYTES)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .crs(crs), .frm_rdy(frm_rdy), .frm_len(frm_len), .rd_addr(rd_addr),
    .rd_data(rd_data), .frm_release(frm_release)
  );

  function automatic logic [7:0] pat_of(input int seed, input int i);
    return 8'(seed * 37 + i * 11 + (i >> 3));
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drives nbytes bytes (plus one extra nibble when odd), tx_er on nibble er_nib.
  task automatic send_frame(input int seed, input int nbytes, input int er_nib,
                            input bit odd, input bit chk_crs);
    for (int n = 0; n < 2 * nbytes + int'(odd); n++) begin
      @(negedge clk);
      if (chk_crs && n == 0) chk_eq("R3 crs before first edge", int'(crs), 0);
      if (chk_crs && n == 1) chk_eq("R3 crs one clock after tx_en", int'(crs), 1);
      if (chk_crs && n == 2 * nbytes - 1) chk_eq("R3 crs held during frame", int'(crs), 1);
      tx_en = 1'b1;
      tx_er = (n == er_nib);
      txd   = n[0] ? pat_of(seed, n / 2)[7:4] : pat_of(seed, n / 2)[3:0];
    end
    @(negedge clk);
    tx_en = 1'b0;
    tx_er = 1'b0;
    txd   = '0;
    @(negedge clk);
  endtask

  task automatic read_frame(input string req, input int seed, input int nbytes);
    int bad = 0;
    chk_eq({req, " frm_rdy"}, int'(frm_rdy), 1);
    chk_eq({req, " frm_len"}, int'(frm_len), nbytes);
    for (int i = 0; i < nbytes; i++) begin
      rd_addr = LEN_W'(i);
      @(negedge clk);
      if (rd_data !== pat_of(seed, i)) begin
        if (bad == 0) chk_eq({req, " first bad byte"}, int'(rd_data), int'(pat_of(seed, i)));
        bad++;
      end
    end
    chk_eq({req, " byte mismatches"}, bad, 0);
  endtask

  task automatic release_frame();
    frm_release = 1'b1;
    @(negedge clk);
    frm_release = 1'b0;
  endtask

  task automatic t_reset();
    chk_eq("R1 crs in reset", int'(crs), 0);
    chk_eq("R1 frm_rdy in reset", int'(frm_rdy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R1 crs idle", int'(crs), 0);
    chk_eq("R1 frm_rdy idle", int'(frm_rdy), 0);
  endtask

  task automatic t_pack_order();
    send_frame(3, 1, -1, 1'b0, 1'b1);
    chk_eq("R4 crs low after end", int'(crs), 0);
    read_frame("R2", 3, 1);
    chk_eq("R2 byte 0x6F low nibble first", int'(rd_data), 8'h6F);
    release_frame();
    chk_eq("R9 frm_rdy after release", int'(frm_rdy), 0);
  endtask

  task automatic t_good_frame();
    send_frame(5, 64, -1, 1'b0, 1'b1);
    chk_eq("R4 crs low after commit", int'(crs), 0);
    read_frame("R9", 5, 64);
    release_frame();
    chk_eq("R9 frm_rdy cleared", int'(frm_rdy), 0);
  endtask

  task automatic t_error_drop();
    send_frame(7, 30, 9, 1'b0, 1'b1);
    chk_eq("R5 errored frame not delivered", int'(frm_rdy), 0);
    chk_eq("R5 crs low after drop", int'(crs), 0);
    send_frame(8, 12, 0, 1'b0, 1'b0);
    chk_eq("R5 error on first nibble drops", int'(frm_rdy), 0);
  endtask

  task automatic t_odd_drop();
    send_frame(9, 20, -1, 1'b1, 1'b0);
    chk_eq("R6 odd nibble frame dropped", int'(frm_rdy), 0);
    send_frame(9, 0, -1, 1'b1, 1'b0);
    chk_eq("R6 single nibble dropped", int'(frm_rdy), 0);
  endtask

  task automatic t_size_limit();
    send_frame(11, BUF_BYTES + 1, -1, 1'b0, 1'b0);
    chk_eq("R7 oversize dropped", int'(frm_rdy), 0);
    chk_eq("R7 crs low after oversize", int'(crs), 0);
    send_frame(12, BUF_BYTES, -1, 1'b0, 1'b0);
    read_frame("R7 full size", 12, BUF_BYTES);
    release_frame();
  endtask

  task automatic t_ring_full();
    send_frame(20, 40, -1, 1'b0, 1'b1);
    chk_eq("R4 crs low, second buffer free", int'(crs), 0);
    send_frame(21, 50, -1, 1'b0, 1'b1);
    chk_eq("R8 crs high with ring full", int'(crs), 1);
    repeat (5) @(negedge clk);
    chk_eq("R8 crs still high", int'(crs), 1);
    send_frame(22, 20, -1, 1'b0, 1'b0);
    chk_eq("R10 forced frame leaves head length", int'(frm_len), 40);
    chk_eq("R10 crs still high after forced frame", int'(crs), 1);
    read_frame("R9 first of two", 20, 40);
    release_frame();
    chk_eq("R8 crs falls on release", int'(crs), 0);
    read_frame("R9 second in order", 21, 50);
    release_frame();
    chk_eq("R10 forced frame never delivered", int'(frm_rdy), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    tx_en = 1'b0;
    tx_er = 1'b0;
    txd = '0;
    frm_release = 1'b0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_pack_order();
    t_good_frame();
    t_error_drop();
    t_odd_drop();
    t_size_limit();
    t_ring_full();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule